// File: doc/BRIEF.md
# Block-transfer host interrupt controller

This block owns the two-bit interrupt mask register of a block-transfer style host/controller mailbox and drives the level-sensitive host interrupt line. It keeps an interrupt-enable bit and an interrupt-pending bit. It decides, from several event sources, when pending is set or cleared. The sources are host writes to the mask register, the mailbox's controller-to-host attention flag, a response-ready pulse, set/clear requests for the system-management attention flag, and warm or cold interface resets. The block also keeps the system-management attention flag, because its changes drive the interrupt decisions.

Message buffering, length checks and command parsing are done elsewhere. That logic raises `rsp_ready` when a reply is ready to read, and it presents the controller-to-host attention flag on `b2h_atn`. The host interrupt output is a registered level. It follows the pending bit, gated by a build-time interrupt-use parameter and by a run-time global enable input.

Top module: `bt_irq_ctrl`

## Requirements
- R1: `mask_rdata` returns the enable bit at bit 0 and the pending bit at bit 1, with every other bit 0. Write-data bits above bit 1 have no effect. After hardware reset, enable, pending, `sms_atn` and `irq` are all 0.
- R2: A mask write whose bit 0 is 1 while enable is 0 sets enable. If `b2h_atn` or the attention flag is 1 at that point, pending is also set. If neither is 1, pending stays 0.
- R3: A mask write whose bit 0 is 0 while enable is 1 clears enable and clears pending.
- R4: A mask write with bit 1 at 1 clears pending if it is set. This is applied after the bit 0 handling of the same write, so writing 0x03 from a disabled state with attention pending leaves enable 1 and pending 0. Writing bit 1 while pending is 0, or rewriting the current enable value, changes nothing.
- R5: A `rsp_ready` pulse sets pending only when enable is 1 and pending is 0. Otherwise it has no effect.
- R6: A request (`atn_req_valid`) whose `atn_req_val` equals the current attention flag changes neither the flag nor pending. A request with a different value loads it into `sms_atn`.
- R7: When a request changes the attention flag from 0 to 1 with `atn_req_irq` at 1, `b2h_atn` at 0 and enable at 1, pending is set. If `atn_req_irq` is 0 or `b2h_atn` is 1, pending is not touched.
- R8: When a request changes the attention flag from 1 to 0 while `b2h_atn` is 0 and pending is 1, pending is cleared. If `b2h_atn` is 1, pending is kept.
- R9: `reset_req` with `reset_cold` at 1 clears enable and pending and overrides every other event in that cycle. With `reset_cold` at 0 it has no effect. Neither form touches the attention flag.
- R10: `irq` is 1 only when pending is 1, `USE_IRQ` is nonzero and `irq_glb_en` was 1 at the same clock edge.
- R11: Events in one cycle are applied in this order: host attention clear (`host_sms_clr`), controller request, response-ready, mask write, cold reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| mask_wr_en | input | 1 | Host write strobe for the mask register |
| mask_wr_data | input | MASK_W | Host write data: bit 0 enable, bit 1 pending-clear |
| mask_rdata | output | MASK_W | Mask register read value |
| b2h_atn | input | 1 | Controller-to-host attention flag from the control register |
| host_sms_clr | input | 1 | Host write clearing the attention flag |
| atn_req_valid | input | 1 | Controller request to set or clear the attention flag |
| atn_req_val | input | 1 | Requested attention flag value |
| atn_req_irq | input | 1 | Request may raise the interrupt |
| rsp_ready | input | 1 | Response-ready pulse |
| reset_req | input | 1 | Interface reset pulse |
| reset_cold | input | 1 | Qualifies `reset_req` as cold |
| irq_glb_en | input | 1 | Global interrupt enable |
| sms_atn | output | 1 | System-management attention flag |
| irq | output | 1 | Level host interrupt |

## Verification
Each result (`mask_rdata`, `sms_atn` and `irq`) is due at the first rising edge after the cycle in which the stimulus is presented. There is one register stage and no further delay. The bench changes inputs on the falling edge and reads outputs on the next falling edge, half a period after the edge that loads them, so no sample lands at an edge. Vectors that combine several events in one cycle show the applied order through this single-cycle result.

// File: rtl/bt_irq_pkg.sv
package bt_irq_pkg;

  localparam int unsigned MASK_W   = 8;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned PEND_BIT = 1;

  typedef struct packed {
    logic pend;
    logic en;
  } irq_state_t;

  // Bit 0 of a mask write: enable edge handling.
  function automatic irq_state_t f_apply_enable(irq_state_t s, logic new_en, logic atn_any);
    irq_state_t r;
    r = s;
    if (new_en != s.en) begin
      if (new_en) begin
        if (atn_any) r.pend = 1'b1;
        r.en = 1'b1;
      end else begin
        r.pend = 1'b0;
        r.en   = 1'b0;
      end
    end
    return r;
  endfunction

  // Bit 1 of a mask write: write-one-to-clear pending.
  function automatic irq_state_t f_apply_ack(irq_state_t s, logic ack);
    irq_state_t r;
    r = s;
    if (ack && s.pend) r.pend = 1'b0;
    return r;
  endfunction

  function automatic irq_state_t f_apply_response(irq_state_t s, logic hit);
    irq_state_t r;
    r = s;
    if (hit && !s.pend && s.en) r.pend = 1'b1;
    return r;
  endfunction

  function automatic irq_state_t f_apply_sms(irq_state_t s, logic rise, logic fall,
                                             logic want_irq, logic b2h);
    irq_state_t r;
    r = s;
    if (rise && want_irq && !b2h && s.en) r.pend = 1'b1;
    if (fall && !b2h && s.pend)           r.pend = 1'b0;
    return r;
  endfunction

  function automatic irq_state_t f_apply_reset(irq_state_t s, logic req, logic cold);
    irq_state_t r;
    r = s;
    if (req && cold) begin
      r.pend = 1'b0;
      r.en   = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/bt_sms_flag.sv
module bt_sms_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic host_clr,
  input  logic req_valid,
  input  logic req_val,
  output logic flag_q,
  output logic flag_d,
  output logic rise_evt,
  output logic fall_evt
);

  logic after_host;
  logic changes;

  always_comb begin
    after_host = flag_q & ~host_clr;
    changes    = req_valid && (req_val != after_host);
    rise_evt   = changes && req_val;
    fall_evt   = changes && !req_val;
    flag_d     = changes ? req_val : after_host;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/bt_mask_core.sv
module bt_mask_core
  import bt_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sms_rise,
  input  logic       sms_fall,
  input  logic       sms_next,
  input  logic       req_irq,
  input  logic       b2h_atn,
  input  logic       rsp_ready,
  input  logic       wr_en,
  input  logic       wr_en_bit,
  input  logic       wr_ack_bit,
  input  logic       reset_req,
  input  logic       reset_cold,
  output irq_state_t state_q,
  output irq_state_t state_d
);

  irq_state_t s_sms, s_rsp, s_en, s_ack;

  always_comb begin
    s_sms = f_apply_sms(state_q, sms_rise, sms_fall, req_irq, b2h_atn);
    s_rsp = f_apply_response(s_sms, rsp_ready);
    s_en  = wr_en ? f_apply_enable(s_rsp, wr_en_bit, b2h_atn | sms_next) : s_rsp;
    s_ack = wr_en ? f_apply_ack(s_en, wr_ack_bit) : s_en;
    state_d = f_apply_reset(s_ack, reset_req, reset_cold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/bt_irq_drive.sv
module bt_irq_drive #(
  parameter bit USE_IRQ = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_next,
  input  logic glb_en,
  output logic irq_q
);

  logic level_d;

  generate
    if (USE_IRQ) begin : g_used
      assign level_d = pend_next & glb_en;
    end else begin : g_unused
      assign level_d = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= level_d;
  end

endmodule

// File: rtl/bt_irq_ctrl.sv
module bt_irq_ctrl
  import bt_irq_pkg::*;
#(
  parameter bit USE_IRQ = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr_en,
  input  logic [MASK_W-1:0] mask_wr_data,
  output logic [MASK_W-1:0] mask_rdata,
  input  logic              b2h_atn,
  input  logic              host_sms_clr,
  input  logic              atn_req_valid,
  input  logic              atn_req_val,
  input  logic              atn_req_irq,
  input  logic              rsp_ready,
  input  logic              reset_req,
  input  logic              reset_cold,
  input  logic              irq_glb_en,
  output logic              sms_atn,
  output logic              irq
);

  logic       sms_d;
  logic       sms_rise_evt;
  logic       sms_fall_evt;
  irq_state_t st_q;
  irq_state_t st_d;

  bt_sms_flag u_sms (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_clr (host_sms_clr),
    .req_valid(atn_req_valid),
    .req_val  (atn_req_val),
    .flag_q   (sms_atn),
    .flag_d   (sms_d),
    .rise_evt (sms_rise_evt),
    .fall_evt (sms_fall_evt)
  );

  bt_mask_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .sms_rise  (sms_rise_evt),
    .sms_fall  (sms_fall_evt),
    .sms_next  (sms_d),
    .req_irq   (atn_req_irq),
    .b2h_atn   (b2h_atn),
    .rsp_ready (rsp_ready),
    .wr_en     (mask_wr_en),
    .wr_en_bit (mask_wr_data[EN_BIT]),
    .wr_ack_bit(mask_wr_data[PEND_BIT]),
    .reset_req (reset_req),
    .reset_cold(reset_cold),
    .state_q   (st_q),
    .state_d   (st_d)
  );

  bt_irq_drive #(.USE_IRQ(USE_IRQ)) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_next(st_d.pend),
    .glb_en   (irq_glb_en),
    .irq_q    (irq)
  );

  always_comb begin
    mask_rdata           = '0;
    mask_rdata[EN_BIT]   = st_q.en;
    mask_rdata[PEND_BIT] = st_q.pend;
  end

endmodule

// File: rtl/bt_irq_ctrl_chk.sv
module bt_irq_ctrl_chk
  import bt_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mask_wr_en,
  input logic [MASK_W-1:0] mask_wr_data,
  input logic [MASK_W-1:0] mask_rdata,
  input logic              host_sms_clr,
  input logic              atn_req_valid,
  input logic              atn_req_val,
  input logic              rsp_ready,
  input logic              reset_req,
  input logic              reset_cold,
  input logic              irq_glb_en,
  input logic              sms_atn,
  input logic              irq
);

  assert_irq_needs_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_rdata[PEND_BIT]);

  assert_irq_needs_glb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_glb_en));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_en && mask_wr_data[PEND_BIT]) |=> !mask_rdata[PEND_BIT]);

  assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_en && !mask_wr_data[EN_BIT]) |=> (mask_rdata[1:0] == 2'b00));

  assert_rsp_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && mask_rdata[EN_BIT] && !mask_wr_en && !reset_req) |=> mask_rdata[PEND_BIT]);

  assert_cold_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req && reset_cold) |=> (mask_rdata[1:0] == 2'b00));

  assert_warm_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req && !reset_cold && !mask_wr_en && !rsp_ready && !atn_req_valid)
      |=> $stable(mask_rdata));

  assert_same_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (atn_req_valid && (atn_req_val == sms_atn) && !host_sms_clr) |=> $stable(sms_atn));

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mask_rdata[MASK_W-1:2] == '0);

endmodule

bind bt_irq_ctrl bt_irq_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mask_wr_en   (mask_wr_en),
  .mask_wr_data (mask_wr_data),
  .mask_rdata   (mask_rdata),
  .host_sms_clr (host_sms_clr),
  .atn_req_valid(atn_req_valid),
  .atn_req_val  (atn_req_val),
  .rsp_ready    (rsp_ready),
  .reset_req    (reset_req),
  .reset_cold   (reset_cold),
  .irq_glb_en   (irq_glb_en),
  .sms_atn      (sms_atn),
  .irq          (irq)
);

// File: tb/bt_irq_ctrl_tb_top.sv
module bt_irq_ctrl_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 22;

  // Vector: wr, wd[1:0], rsp, b2h, rv, rval, rirq, hclr, glb | exp pend, en, sms, irq
  localparam logic [13:0] VEC [NVEC] = '{
    14'b0_00_1_0_0_0_0_0_1_0_0_0_0,  // R5 rsp while disabled
    14'b1_01_0_0_0_0_0_0_1_0_1_0_0,  // R2 enable, no attention
    14'b0_00_1_0_0_0_0_0_1_1_1_0_1,  // R5 rsp raises
    14'b0_00_1_0_0_0_0_0_1_1_1_0_1,  // R5 rsp while pending
    14'b1_11_0_0_0_0_0_0_1_0_1_0_0,  // R4 ack clears
    14'b1_10_0_0_0_0_0_0_1_0_0_0_0,  // R3 disable, R4 ack with no pending
    14'b0_00_0_0_1_1_1_0_1_0_0_1_0,  // R7 set while disabled
    14'b1_01_0_0_0_0_0_0_1_1_1_1_1,  // R2 enable with attention
    14'b0_00_0_0_1_1_1_0_1_1_1_1_1,  // R6 same value
    14'b0_00_0_1_1_0_0_0_1_1_1_0_1,  // R8 clear with b2h set
    14'b1_00_0_1_0_0_0_0_1_0_0_0_0,  // R3 disable clears pending
    14'b1_01_0_1_0_0_0_0_1_1_1_0_1,  // R2 enable with b2h
    14'b1_11_0_1_0_0_0_0_1_0_1_0_0,  // R4 0x03 keeps enable, clears pending
    14'b0_00_0_1_1_1_1_0_1_0_1_1_0,  // R7 b2h blocks
    14'b0_00_0_0_1_0_0_0_1_0_1_0_0,  // R8 clear with no pending
    14'b0_00_0_0_1_1_0_0_1_0_1_1_0,  // R7 no qualifier
    14'b0_00_1_0_0_0_0_0_1_1_1_1_1,  // R5 rsp raises
    14'b0_00_0_0_1_0_0_0_1_0_1_0_0,  // R8 clear lowers
    14'b0_00_1_0_0_0_0_0_0_1_1_0_0,  // R10 global enable off
    14'b0_00_0_0_0_0_0_0_1_1_1_0_1,  // R10 global enable on
    14'b1_11_1_0_0_0_0_0_1_0_1_0_0,  // R11 rsp before ack
    14'b0_00_0_0_1_1_1_1_1_1_1_1_1   // R11 host clear before request
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mask_wr_en = 1'b0;
  logic [7:0] mask_wr_data = '0;
  logic [7:0] mask_rdata;
  logic       b2h_atn = 1'b0;
  logic       host_sms_clr = 1'b0;
  logic       atn_req_valid = 1'b0;
  logic       atn_req_val = 1'b0;
  logic       atn_req_irq = 1'b0;
  logic       rsp_ready = 1'b0;
  logic       reset_req = 1'b0;
  logic       reset_cold = 1'b0;
  logic       irq_glb_en = 1'b1;
  logic       sms_atn;
  logic       irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bt_irq_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_data (mask_wr_data),
    .mask_rdata   (mask_rdata),
    .b2h_atn      (b2h_atn),
    .host_sms_clr (host_sms_clr),
    .atn_req_valid(atn_req_valid),
    .atn_req_val  (atn_req_val),
    .atn_req_irq  (atn_req_irq),
    .rsp_ready    (rsp_ready),
    .reset_req    (reset_req),
    .reset_cold   (reset_cold),
    .irq_glb_en   (irq_glb_en),
    .sms_atn      (sms_atn),
    .irq          (irq)
  );

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag, logic p, logic e, logic s, logic i);
    check(tag, {mask_rdata, sms_atn, irq}, {6'b0, p, e, s, i});
  endtask

  task automatic idle_inputs();
    mask_wr_en = 1'b0; mask_wr_data = '0; rsp_ready = 1'b0;
    atn_req_valid = 1'b0; atn_req_val = 1'b0; atn_req_irq = 1'b0;
    host_sms_clr = 1'b0; reset_req = 1'b0; reset_cold = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset state", 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      mask_wr_en    = VEC[k][13];
      mask_wr_data  = {6'b111111, VEC[k][12:11]};  // R1 upper bits ignored
      rsp_ready     = VEC[k][10];
      b2h_atn       = VEC[k][9];
      atn_req_valid = VEC[k][8];
      atn_req_val   = VEC[k][7];
      atn_req_irq   = VEC[k][6];
      host_sms_clr  = VEC[k][5];
      irq_glb_en    = VEC[k][4];
      @(negedge clk);
      check_all($sformatf("vector %0d (R1..R11 table)", k),
                VEC[k][3], VEC[k][2], VEC[k][1], VEC[k][0]);
      idle_inputs();
    end

    // State now: pend 1, en 1, sms 1, irq 1
    b2h_atn = 1'b0; irq_glb_en = 1'b1;
    reset_req = 1'b1; reset_cold = 1'b0;
    @(negedge clk);
    check_all("R9 warm reset no effect", 1'b1, 1'b1, 1'b1, 1'b1);
    idle_inputs();

    reset_req = 1'b1; reset_cold = 1'b1; rsp_ready = 1'b1;
    mask_wr_en = 1'b1; mask_wr_data = 8'h01;
    @(negedge clk);
    check_all("R9 cold reset overrides", 1'b0, 1'b0, 1'b1, 1'b0);
    idle_inputs();

    rsp_ready = 1'b1;
    @(negedge clk);
    check_all("R5 rsp after cold reset", 1'b0, 1'b0, 1'b1, 1'b0);
    idle_inputs();

    host_sms_clr = 1'b1;
    @(negedge clk);
    check_all("R11 host clear alone", 1'b0, 1'b0, 1'b0, 1'b0);
    idle_inputs();

    mask_wr_en = 1'b1; mask_wr_data = 8'h01;
    @(negedge clk);
    idle_inputs();
    rsp_ready = 1'b1;
    @(negedge clk);
    check_all("R5 raise before hw reset", 1'b1, 1'b1, 1'b0, 1'b1);
    idle_inputs();

    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1 hardware reset mid-run", 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule